// File: doc/BRIEF.md
# Word-Serial Bignum Multiply-Accumulate Engine

The engine walks an array of 16-bit words and scales it by a single 16-bit factor `k`, one word at a time, starting at the least significant word. It has three operations. Plain multiply stores `in*k` into a destination array. Multiply-add adds `in*k` into the destination. Multiply-subtract takes `in*k` away from the destination. Both arrays live in a small internal memory. The memory has two synchronous read ports and one write port. A host loads and inspects it through a simple word port while the engine is idle.

One `start` pulse launches an operation. The pulse carries the opcode, the length minus one, `k`, and the base addresses of the source and destination arrays. Each step multiplies one source word by `k` to form a 32-bit product. It adds the carry word left from the previous step. The low half is stored, or added or subtracted in the add and subtract modes. The high half, plus any carry or borrow from that 16-bit add or subtract, becomes the next carry. When the last step ends, the final carry word is placed on `carry_out` and `done` pulses.

The controller has five states:
- IDLE waits for a legal `start` and goes to FETCH.
- FETCH reads both arrays at the current index and always goes to CALC.
- CALC writes one result word. If more words remain it returns to FETCH. After the last word it goes to TAIL for plain multiply, or to FIN otherwise.
- TAIL writes the final carry one word past the array and goes to FIN.
- FIN raises `done` and returns to IDLE.

Top module: `wsmac_engine`

## Requirements
- R1: Words are processed from index 0 upward. In plain multiply (op code 0), destination word i becomes the low 16 bits of `src[i]*k + c`, where `c` is the carry from step i-1, or 0 for i = 0. The high 16 bits of that sum become the next carry.
- R2: In plain multiply, the final carry is written to destination index n, where n is the length. It is also shown on `carry_out`.
- R3: In multiply-add (op code 1), the low half of the product-plus-carry is added to the existing destination word. The carry out of that 16-bit addition is added to the next carry.
- R4: In multiply-subtract (op code 2), the low half is subtracted from the existing destination word. The borrow of that subtraction is added to the next carry.
- R5: In multiply-add and multiply-subtract, destination index n is left untouched. The final carry appears only on `carry_out`, which holds its value until the next operation finishes.
- R6: The length is `len_m1 + 1`, so any length from 1 to 65536 words is possible. A length of 1 finishes after a single step. Addresses are the base plus the index, modulo the memory depth (256 words by default).
- R7: `busy` rises on the clock edge that accepts `start`. Each word takes two cycles. `done` is high for exactly one cycle, starting on the edge after the last memory write, and `busy` falls on the edge that follows.
- R8: A `start` that arrives while `busy` is high is ignored, and so is a `start` with op code 3.
- R9: While the engine is idle, `host_we` writes `host_wdata` at `host_addr`, and `host_rdata` shows the word at `host_addr` one cycle after the address is presented. A host write made while the engine is busy is ignored.
- R10: After reset, `busy`, `done` and `carry_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse |
| op | input | 2 | 0 multiply, 1 multiply-add, 2 multiply-subtract, 3 illegal |
| len_m1 | input | 16 | Word count minus one |
| k | input | 16 | Scalar factor |
| src_base | input | 8 | Source array base address |
| dst_base | input | 8 | Destination array base address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 16 | Final carry or borrow word |
| host_we | input | 1 | Host write enable |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle latency |

## Verification
The embedded assertions check the following on every cycle:
- `done` lasts a single cycle.
- `done` follows a memory write.
- The operation's parameters stay frozen while a second `start` arrives mid-run.
- The step index never runs past the length.

The word arithmetic can only be shown by the bench scenarios: the carry chains, the borrows, and where the final carry lands. The same holds for leaving destination index n alone in the add and subtract modes, and for the blocked host writes. The bench compares memory contents and `carry_out` against a behavioural model, and checks `busy` and `done` against the predicted cycle count on every clock.

// File: rtl/wsmac_pkg.sv
package wsmac_pkg;
    typedef enum logic [1:0] {
        OP_MUL  = 2'd0,
        OP_MADD = 2'd1,
        OP_MSUB = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CALC,
        S_TAIL,
        S_FIN
    } state_e;
endpackage

// File: rtl/wsmac_mem.sv
module wsmac_mem #(
    parameter int W  = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] ra_addr,
    output logic [W-1:0]  ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[wa] <= wd;
        ra_data <= store[ra_addr];
        rb_data <= store[rb_addr];
    end
endmodule

// File: rtl/wsmac_step.sv
module wsmac_step
    import wsmac_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op,
    input  logic [W-1:0] in_word,
    input  logic [W-1:0] out_word,
    input  logic [W-1:0] k,
    input  logic [W-1:0] carry_in,
    output logic [W-1:0] res_word,
    output logic [W-1:0] carry_next
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic [W:0]    acc;
    logic          extra;

    always_comb begin
        prod  = PW'(in_word) * PW'(k) + PW'(carry_in);
        acc   = '0;
        extra = 1'b0;
        unique case (op)
            OP_MADD: begin
                acc   = {1'b0, out_word} + {1'b0, prod[W-1:0]};
                extra = acc[W];
            end
            OP_MSUB: begin
                acc   = {1'b0, out_word} - {1'b0, prod[W-1:0]};
                extra = acc[W];
            end
            default: begin
                acc   = {1'b0, prod[W-1:0]};
                extra = 1'b0;
            end
        endcase
        res_word   = acc[W-1:0];
        carry_next = prod[PW-1:W] + W'(extra);
    end
endmodule

// File: rtl/wsmac_engine.sv
module wsmac_engine
    import wsmac_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 8,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [LW-1:0] len_m1,
    input  logic [W-1:0]  k,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  carry_out,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [W-1:0]  host_wdata,
    output logic [W-1:0]  host_rdata
);
    state_e        state_q, state_d;
    op_e           op_q;
    logic [W-1:0]  k_q, carry_q, cout_q;
    logic [LW-1:0] len_q, idx_q;
    logic [AW-1:0] sbase_q, dbase_q;

    logic          start_ok, last_word;
    logic [AW-1:0] ra_addr, rb_addr, mem_wa;
    logic [W-1:0]  ra_data, rb_data, mem_wd;
    logic          eng_we, mem_we;
    logic [W-1:0]  step_res, step_carry;

    assign start_ok  = start && (op_e'(op) != OP_NONE);
    assign last_word = (idx_q == len_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_ok) state_d = S_FETCH;
            S_FETCH: state_d = S_CALC;
            S_CALC: begin
                if (!last_word)         state_d = S_FETCH;
                else if (op_q == OP_MUL) state_d = S_TAIL;
                else                     state_d = S_FIN;
            end
            S_TAIL:  state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Operation context and step registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_MUL;
            k_q     <= '0;
            len_q   <= '0;
            sbase_q <= '0;
            dbase_q <= '0;
            idx_q   <= '0;
            carry_q <= '0;
            cout_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_ok) begin
                        op_q    <= op_e'(op);
                        k_q     <= k;
                        len_q   <= len_m1;
                        sbase_q <= src_base;
                        dbase_q <= dst_base;
                        idx_q   <= '0;
                        carry_q <= '0;
                    end
                end
                S_CALC: begin
                    carry_q <= step_carry;
                    if (!last_word || op_q == OP_MUL) idx_q <= idx_q + 1'b1;
                    if (last_word) cout_q <= step_carry;
                end
                default: ;
            endcase
        end
    end

    // Outputs and memory steering
    always_comb begin
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_FIN);
        carry_out  = cout_q;
        host_rdata = ra_data;
        ra_addr    = busy ? sbase_q + idx_q[AW-1:0] : host_addr;
        rb_addr    = dbase_q + idx_q[AW-1:0];
        eng_we     = (state_q == S_CALC) || (state_q == S_TAIL);
        mem_we     = eng_we || (host_we && !busy);
        mem_wa     = eng_we ? dbase_q + idx_q[AW-1:0] : host_addr;
        mem_wd     = (state_q == S_TAIL) ? carry_q
                   : (state_q == S_CALC) ? step_res : host_wdata;
    end

    wsmac_step #(.W(W)) step_i (
        .op         (op_q),
        .in_word    (ra_data),
        .out_word   (rb_data),
        .k          (k_q),
        .carry_in   (carry_q),
        .res_word   (step_res),
        .carry_next (step_carry)
    );

    wsmac_mem #(.W(W), .AW(AW)) mem_i (
        .clk     (clk),
        .ra_addr (ra_addr),
        .ra_data (ra_data),
        .rb_addr (rb_addr),
        .rb_data (rb_data),
        .we      (mem_we),
        .wa      (mem_wa),
        .wd      (mem_wd)
    );

    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_we));

    // R8
    start_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(k_q) && $stable(len_q) && $stable(op_q)));

    // R6
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH) |-> (idx_q <= len_q));
endmodule

// File: tb/wsmac_engine_tb_top.sv
`timescale 1ns/1ps
module wsmac_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [15:0] len_m1 = '0;
    logic [15:0] k = '0;
    logic [7:0]  src_base = '0;
    logic [7:0]  dst_base = '0;
    logic        busy, done;
    logic [15:0] carry_out;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] model [256];
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    wsmac_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .len_m1(len_m1),
        .k(k), .src_base(src_base), .dst_base(dst_base), .busy(busy),
        .done(done), .carry_out(carry_out), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish act=%0d exp=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr;
    endfunction

    task automatic host_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        model[a] = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read_chk(input logic [7:0] a, input string tag);
        @(negedge clk);
        host_addr = a;
        @(negedge clk);
        chk(host_rdata === model[a], tag, {16'h0, host_rdata}, {16'h0, model[a]});
    endtask

    // Behavioural reference: updates model memory and returns the final carry.
    function automatic logic [15:0] ref_op(input int o, input int n, input int kk,
                                           input int sb, input int db);
        longint c = 0;
        for (int i = 0; i < n; i++) begin
            longint p = longint'(model[(sb + i) % 256]) * kk + c;
            longint lo = p % 65536;
            longint hi = p / 65536;
            longint ow = model[(db + i) % 256];
            if (o == 0) begin
                model[(db + i) % 256] = 16'(lo);
                c = hi;
            end else if (o == 1) begin
                longint s = ow + lo;
                model[(db + i) % 256] = 16'(s % 65536);
                c = hi + s / 65536;
            end else begin
                longint b = (ow < lo) ? 1 : 0;
                model[(db + i) % 256] = 16'((ow - lo + 65536) % 65536);
                c = hi + b;
            end
        end
        if (o == 0) model[(db + n) % 256] = 16'(c);
        return 16'(c);
    endfunction

    // Launch one operation and compare busy/done to the predicted schedule every cycle.
    task automatic run_op(input int o, input int n, input logic [15:0] kk,
                          input int sb, input int db, input bit disturb, input string tag);
        logic [15:0] exp_c;
        int t;
        t = 2 * n + ((o == 0) ? 1 : 0);
        @(negedge clk);
        op = 2'(o); len_m1 = 16'(n - 1); k = kk;
        src_base = 8'(sb); dst_base = 8'(db); start = 1'b1;
        exp_c = ref_op(o, n, kk, sb, db);
        for (int j = 0; j <= t + 1; j++) begin
            @(negedge clk);
            start = 1'b0; host_we = 1'b0;
            if (disturb && j == 1) begin
                // R8: second start mid-run; R9: host write while busy
                start = 1'b1; op = 2'd1; k = 16'h1234; len_m1 = 16'd40;
                host_we = 1'b1; host_addr = 8'd250; host_wdata = 16'hBEEF;
            end
            if (j <= t) begin
                chk(busy === 1'b1, {tag, " R7 busy"}, {31'h0, busy}, 32'h1);
                chk(done === (j == t), {tag, " R7 done timing"}, {31'h0, done}, {31'h0, j == t});
                if (j == t)
                    chk(carry_out === exp_c, {tag, " R5 carry_out"}, {16'h0, carry_out}, {16'h0, exp_c});
            end else begin
                chk(busy === 1'b0 && done === 1'b0, {tag, " R7 idle after"}, {30'h0, busy, done}, 32'h0);
            end
        end
        chk(carry_out === exp_c, {tag, " R5 carry_out held"}, {16'h0, carry_out}, {16'h0, exp_c});
        for (int i = 0; i <= n; i++)
            host_read_chk(8'((db + i) % 256), {tag, " R1 R2 R3 R4 dest word"});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy === 1'b0 && done === 1'b0, "R10 reset flags", {30'h0, busy, done}, 32'h0);
        chk(carry_out === 16'h0, "R10 reset carry", {16'h0, carry_out}, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) host_write(8'(i), 16'h0);
        for (int i = 0; i < 8; i++) host_write(8'(i), next_rand());
        host_write(8'd250, 16'h5A5A);
        host_read_chk(8'd3, "R9 host readback");

        // R1 R2 plain multiply, length 4
        run_op(0, 4, 16'hABCD, 0, 64, 1'b0, "mul4");
        // R6 length 1, maximum operands
        host_write(8'd20, 16'hFFFF);
        run_op(0, 1, 16'hFFFF, 20, 100, 1'b0, "mul1");
        // R3 multiply-add with full carry chains
        for (int i = 0; i < 5; i++) begin
            host_write(8'(30 + i), 16'hFFFF);
            host_write(8'(120 + i), 16'hFFFF);
        end
        host_write(8'd125, 16'h7777);
        run_op(1, 5, 16'hFFFF, 30, 120, 1'b0, "madd5");
        // R4 multiply-subtract from zero, with a mid-run start and host write
        host_write(8'd145, 16'h3C3C);
        run_op(2, 3, 16'h9E37, 0, 142, 1'b1, "msub3");
        host_read_chk(8'd250, "R9 busy host write ignored");
        // R4 subtract into random contents, wrapping past the memory end
        for (int i = 0; i < 6; i++) host_write(8'(252 + i), next_rand());
        run_op(2, 6, 16'h0101, 2, 252, 1'b0, "msub_wrap");
        // R3 multiply-add in place
        run_op(1, 4, 16'h0003, 64, 64, 1'b0, "madd_inplace");

        // R8 illegal opcode is ignored
        @(negedge clk);
        op = 2'd3; len_m1 = 16'd2; k = 16'h4444; src_base = 8'd0; dst_base = 8'd64; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b0, "R8 op3 ignored", {31'h0, busy}, 32'h0);
        host_read_chk(8'd64, "R8 op3 no write");
        host_read_chk(8'd65, "R8 op3 no write");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule